// File: doc/BRIEF.md
# Nested Interrupt Acknowledge and Completion Tracker

This block tracks, for each processor, the interrupt that is currently being serviced and the chain of interrupts it preempted. An acknowledge strobe from a processor samples the highest-pending ID that an external arbiter supplies for that processor. If that interrupt is more urgent than the running one, the tracker makes it the running interrupt, records the one it displaced as its link entry, and issues a pending-clear command. Otherwise it answers with the spurious ID 1023.

An end-of-interrupt (EOI) strobe retires an ID. Retiring the running ID pops the chain and restores the priority of the interrupt underneath. Retiring an ID buried deeper in the chain splices that ID out: a walker follows the links one entry per clock until it finds the entry that points at the ID, and `busy_o` stays high while it does. A valid EOI also re-arms a level-sensitive source that is still asserted, enabled and targeted for that processor, by issuing a pending-set command. Priority arbitration and the pending bits themselves are outside the block; priorities come from a combinational lookup port.

Top module: `irq_ack_tracker`

## Requirements
- R1: After reset, every processor's running ID is 1023, its running priority is 0x100 (9 bits), `busy_o` is low, and neither result pulse is asserted.
- R2: An acknowledge is answered one cycle after its strobe with `ack_valid_o` high for one cycle and `ack_id_o` = 1023 when the highest-pending ID is 1023 or its 8-bit priority is not strictly below the running priority. The running state is then unchanged.
- R3: A successful acknowledge returns the highest-pending ID on `ack_id_o`. In the same cycle, that processor's running ID becomes that ID and its running priority becomes that ID's priority.
- R4: With a successful acknowledge, `pend_clr_o` pulses in the same cycle as `ack_valid_o`, carrying the ID. Its mask has all processor bits set when the ID's one-of-N flag is 1, and otherwise only the bit of the acknowledging processor (bit n = processor n).
- R5: An EOI whose 10-bit ID is at or above NUM_IRQ (1023 included) is ignored. So is any EOI to a processor whose running ID is 1023. Such an EOI leaves the running state unchanged and raises no command.
- R6: An EOI naming the running ID takes effect one cycle after the strobe. The running ID becomes the link entry of the retired ID. The running priority becomes that entry's priority, or 0x100 when the entry is 1023.
- R7: An EOI naming an ID below the running one removes it from the chain and leaves the running ID and priority untouched. Later pops skip the removed ID. An ID not found in the chain changes nothing.
- R8: A chain walk takes one cycle per link followed. `busy_o` is high for exactly d cycles from the cycle after the strobe, where d is the ID's depth below the running entry (1 for the entry directly beneath it). When the ID is absent, d is the total chain depth.
- R9: A valid EOI (per R5) produces a one-cycle `pend_set_o` one cycle after the strobe, with the ID and the one-hot mask of the retiring processor. It does so only when the ID's edge flag is 0 and its enable, level and target bits for that processor are all 1.
- R10: Acknowledges and EOIs on one processor never change another processor's running ID or priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ack_req_i | input | 1 | Acknowledge strobe (takes precedence over an EOI strobe in the same cycle) |
| ack_cpu_i | input | CPU_W | Acknowledging processor |
| hp_id_i | input | NUM_CPU*10 | Highest-pending ID per processor, processor n at bits [10n+9:10n] |
| eoi_req_i | input | 1 | End-of-interrupt strobe |
| eoi_cpu_i | input | CPU_W | Retiring processor |
| eoi_id_i | input | 10 | ID being retired |
| prio_qry_id_o | output | 10 | ID whose priority is looked up this cycle |
| prio_qry_cpu_o | output | CPU_W | Processor for the priority lookup |
| prio_qry_val_i | input | 8 | Combinational priority answer (lower is more urgent) |
| trig_edge_i | input | NUM_IRQ | Per ID: 1 = edge-triggered, 0 = level-sensitive |
| one_of_n_i | input | NUM_IRQ | Per ID: 1 = clear pending for all processors on acknowledge |
| en_i | input | NUM_IRQ*NUM_CPU | Enable, bit id*NUM_CPU+cpu |
| level_i | input | NUM_IRQ*NUM_CPU | Source level seen by each processor, same layout |
| target_i | input | NUM_IRQ*NUM_CPU | Target bits, same layout |
| ack_valid_o | output | 1 | One-cycle acknowledge answer |
| ack_id_o | output | 10 | Acknowledged ID or 1023 |
| run_id_o | output | NUM_CPU*10 | Running ID per processor |
| run_prio_o | output | NUM_CPU*9 | Running priority per processor, 0x100 when idle |
| busy_o | output | 1 | Chain walk in progress; strobes are not accepted |
| pend_clr_o | output | 1 | Pending-clear command pulse |
| pend_clr_id_o | output | 10 | ID to clear |
| pend_clr_mask_o | output | NUM_CPU | Processors whose pending bit is cleared |
| pend_set_o | output | 1 | Pending-set command pulse |
| pend_set_id_o | output | 10 | ID to set pending |
| pend_set_mask_o | output | NUM_CPU | Processor whose pending bit is set |

## Verification
The checks assume the environment sends at most one strobe per cycle and none while `busy_o` is high. They also assume the arbiter offers only IDs below NUM_IRQ or 1023, and that the priority lookup answers combinationally and does not change between an acknowledge and the matching completion. Under these conditions a chain never holds the same ID twice and never links an entry to itself. The stimulus issues every strobe from a task that holds it for one cycle and then waits for `busy_o` to fall before the next one. The priority table is fixed for the whole run.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int ID_W    = 10;
  localparam int PRIO_W  = 8;
  localparam int RPRIO_W = PRIO_W + 1;

  localparam logic [ID_W-1:0]    ID_NONE   = '1;
  localparam logic [RPRIO_W-1:0] PRIO_IDLE = RPRIO_W'(1) << PRIO_W;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walk_st_e;
endpackage

// File: rtl/irq_link_table.sv
module irq_link_table
  import irq_ack_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_IRQ = 64,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CPU_W-1:0] wr_cpu,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ID_W-1:0]  wr_data,
  input  logic [CPU_W-1:0] rd_cpu,
  input  logic [IDX_W-1:0] rd_idx_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output logic [ID_W-1:0]  rd_data_a,
  output logic [ID_W-1:0]  rd_data_b
);

  // One link entry per (processor, ID): the ID that was running when this one was taken.
  logic [ID_W-1:0] link_q [NUM_CPU][NUM_IRQ];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CPU; c++) begin
        for (int i = 0; i < NUM_IRQ; i++) begin
          link_q[c][i] <= ID_NONE;
        end
      end
    end else if (wr_en) begin
      link_q[wr_cpu][wr_idx] <= wr_data;
    end
  end

  assign rd_data_a = link_q[rd_cpu][rd_idx_a];
  assign rd_data_b = link_q[rd_cpu][rd_idx_b];

  AST_LINK_NO_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data != ID_W'(wr_idx))); // R3

endmodule

// File: rtl/irq_run_bank.sv
module irq_run_bank
  import irq_ack_pkg::*;
#(
  parameter int NUM_CPU = 2,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             ld_en,
  input  logic [CPU_W-1:0]                 ld_cpu,
  input  logic [ID_W-1:0]                  ld_id,
  input  logic [RPRIO_W-1:0]               ld_prio,
  output logic [NUM_CPU-1:0][ID_W-1:0]     run_id,
  output logic [NUM_CPU-1:0][RPRIO_W-1:0]  run_prio
);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [ID_W-1:0]    id_q, id_d;
    logic [RPRIO_W-1:0] prio_q, prio_d;
    logic               hit;

    assign hit = ld_en && (ld_cpu == CPU_W'(c));

    always_comb begin
      id_d   = id_q;
      prio_d = prio_q;
      if (hit) begin
        id_d   = ld_id;
        prio_d = ld_prio;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        id_q   <= ID_NONE;
        prio_q <= PRIO_IDLE;
      end else if (hit) begin
        id_q   <= id_d;
        prio_q <= prio_d;
      end
    end

    assign run_id[c]   = id_q;
    assign run_prio[c] = prio_q;

    AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
      (id_q == ID_NONE) |-> (prio_q == PRIO_IDLE)); // R6
  end

endmodule

// File: rtl/irq_ack_tracker.sv
module irq_ack_tracker
  import irq_ack_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_IRQ = 64,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ack_req_i,
  input  logic [CPU_W-1:0]             ack_cpu_i,
  input  logic [NUM_CPU*ID_W-1:0]      hp_id_i,
  input  logic                         eoi_req_i,
  input  logic [CPU_W-1:0]             eoi_cpu_i,
  input  logic [ID_W-1:0]              eoi_id_i,
  output logic [ID_W-1:0]              prio_qry_id_o,
  output logic [CPU_W-1:0]             prio_qry_cpu_o,
  input  logic [PRIO_W-1:0]            prio_qry_val_i,
  input  logic [NUM_IRQ-1:0]           trig_edge_i,
  input  logic [NUM_IRQ-1:0]           one_of_n_i,
  input  logic [NUM_IRQ*NUM_CPU-1:0]   en_i,
  input  logic [NUM_IRQ*NUM_CPU-1:0]   level_i,
  input  logic [NUM_IRQ*NUM_CPU-1:0]   target_i,
  output logic                         ack_valid_o,
  output logic [ID_W-1:0]              ack_id_o,
  output logic [NUM_CPU*ID_W-1:0]      run_id_o,
  output logic [NUM_CPU*RPRIO_W-1:0]   run_prio_o,
  output logic                         busy_o,
  output logic                         pend_clr_o,
  output logic [ID_W-1:0]              pend_clr_id_o,
  output logic [NUM_CPU-1:0]           pend_clr_mask_o,
  output logic                         pend_set_o,
  output logic [ID_W-1:0]              pend_set_id_o,
  output logic [NUM_CPU-1:0]           pend_set_mask_o
);

  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int CNT_W = IDX_W + 2;
  localparam logic [ID_W-1:0] IRQ_LIM = ID_W'(NUM_IRQ);

  // Reshaped views of the flat inputs
  logic [NUM_CPU-1:0][ID_W-1:0]    hp_arr;
  logic [NUM_IRQ-1:0][NUM_CPU-1:0] en_arr, lvl_arr, tgt_arr;
  assign hp_arr  = hp_id_i;
  assign en_arr  = en_i;
  assign lvl_arr = level_i;
  assign tgt_arr = target_i;

  // State
  walk_st_e         st_q, st_d;
  logic [CPU_W-1:0] wcpu_q, wcpu_d;
  logic [IDX_W-1:0] wcur_q, wcur_d;
  logic [ID_W-1:0]  wtgt_q, wtgt_d;

  logic               ackv_q, ackv_d;
  logic [ID_W-1:0]    ackid_q, ackid_d;
  logic               pclr_q, pclr_d;
  logic [ID_W-1:0]    pclr_id_q;
  logic [NUM_CPU-1:0] pclr_m_q, pclr_m_d;
  logic               pset_q, pset_d;
  logic [ID_W-1:0]    pset_id_q;
  logic [NUM_CPU-1:0] pset_m_q, pset_m_d;

  // Sub-block wiring
  logic [NUM_CPU-1:0][ID_W-1:0]    run_id;
  logic [NUM_CPU-1:0][RPRIO_W-1:0] run_prio;
  logic               lk_wr_en;
  logic [CPU_W-1:0]   lk_wr_cpu, lk_rd_cpu;
  logic [IDX_W-1:0]   lk_wr_idx, lk_rd_a, lk_rd_b;
  logic [ID_W-1:0]    lk_wr_data, lk_a, lk_b;
  logic               ld_en;
  logic [CPU_W-1:0]   ld_cpu;
  logic [ID_W-1:0]    ld_id;
  logic [RPRIO_W-1:0] ld_prio;

  // Decode
  logic               idle, take_ack, take_eoi, ack_ok, eoi_ok, eoi_pop, eoi_walk;
  logic               splice, repend;
  logic [ID_W-1:0]    a_hp, a_run_id, e_run;
  logic [RPRIO_W-1:0] a_run_prio, qry_prio;
  logic [IDX_W-1:0]   a_idx, e_idx;

  assign idle       = (st_q == ST_IDLE);
  assign a_hp       = hp_arr[ack_cpu_i];
  assign a_idx      = a_hp[IDX_W-1:0];
  assign a_run_id   = run_id[ack_cpu_i];
  assign a_run_prio = run_prio[ack_cpu_i];
  assign e_run      = run_id[eoi_cpu_i];
  assign e_idx      = eoi_id_i[IDX_W-1:0];
  assign qry_prio   = {1'b0, prio_qry_val_i};

  assign take_ack = idle && ack_req_i;
  assign take_eoi = idle && eoi_req_i && !ack_req_i;
  assign ack_ok   = take_ack && (a_hp != ID_NONE) && (a_hp < IRQ_LIM) && (qry_prio < a_run_prio);
  assign eoi_ok   = take_eoi && (eoi_id_i < IRQ_LIM) && (e_run != ID_NONE);
  assign eoi_pop  = eoi_ok && (eoi_id_i == e_run);
  assign eoi_walk = eoi_ok && (eoi_id_i != e_run);
  assign splice   = (st_q == ST_WALK) && (lk_a == wtgt_q);
  assign repend   = eoi_ok && !trig_edge_i[e_idx] && en_arr[e_idx][eoi_cpu_i]
                    && lvl_arr[e_idx][eoi_cpu_i] && tgt_arr[e_idx][eoi_cpu_i];

  // Priority lookup: the acknowledge candidate, or the entry a pop would restore
  assign prio_qry_id_o  = take_ack ? a_hp : lk_a;
  assign prio_qry_cpu_o = take_ack ? ack_cpu_i : eoi_cpu_i;

  // Link table access
  assign lk_rd_cpu  = idle ? eoi_cpu_i : wcpu_q;
  assign lk_rd_a    = idle ? e_run[IDX_W-1:0] : wcur_q;
  assign lk_rd_b    = wtgt_q[IDX_W-1:0];
  assign lk_wr_en   = ack_ok || splice;
  assign lk_wr_cpu  = ack_ok ? ack_cpu_i : wcpu_q;
  assign lk_wr_idx  = ack_ok ? a_idx : wcur_q;
  assign lk_wr_data = ack_ok ? a_run_id : lk_b;

  // Running register load
  assign ld_en   = ack_ok || eoi_pop;
  assign ld_cpu  = ack_ok ? ack_cpu_i : eoi_cpu_i;
  assign ld_id   = ack_ok ? a_hp : lk_a;
  assign ld_prio = (!ack_ok && (lk_a == ID_NONE)) ? PRIO_IDLE : qry_prio;

  irq_link_table #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) u_links (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (lk_wr_en),
    .wr_cpu    (lk_wr_cpu),
    .wr_idx    (lk_wr_idx),
    .wr_data   (lk_wr_data),
    .rd_cpu    (lk_rd_cpu),
    .rd_idx_a  (lk_rd_a),
    .rd_idx_b  (lk_rd_b),
    .rd_data_a (lk_a),
    .rd_data_b (lk_b)
  );

  irq_run_bank #(.NUM_CPU(NUM_CPU)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (ld_en),
    .ld_cpu   (ld_cpu),
    .ld_id    (ld_id),
    .ld_prio  (ld_prio),
    .run_id   (run_id),
    .run_prio (run_prio)
  );

  // Next state
  always_comb begin
    st_d     = st_q;
    wcpu_d   = wcpu_q;
    wcur_d   = wcur_q;
    wtgt_d   = wtgt_q;
    ackv_d   = take_ack;
    ackid_d  = ack_ok ? a_hp : ID_NONE;
    pclr_d   = ack_ok;
    pclr_m_d = one_of_n_i[a_idx] ? '1 : (NUM_CPU'(1) << ack_cpu_i);
    pset_d   = repend;
    pset_m_d = NUM_CPU'(1) << eoi_cpu_i;
    if (st_q == ST_IDLE) begin
      if (eoi_walk) begin
        st_d   = ST_WALK;
        wcpu_d = eoi_cpu_i;
        wcur_d = e_run[IDX_W-1:0];
        wtgt_d = eoi_id_i;
      end
    end else begin
      if (splice || (lk_a == ID_NONE)) begin
        st_d = ST_IDLE;
      end else begin
        wcur_d = lk_a[IDX_W-1:0];
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wcpu_q <= '0;
      wcur_q <= '0;
      wtgt_q <= ID_NONE;
    end else begin
      st_q <= st_d;
      if (eoi_walk || (st_q == ST_WALK)) begin
        wcpu_q <= wcpu_d;
        wcur_q <= wcur_d;
        wtgt_q <= wtgt_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ackv_q    <= 1'b0;
      ackid_q   <= ID_NONE;
      pclr_q    <= 1'b0;
      pclr_id_q <= ID_NONE;
      pclr_m_q  <= '0;
      pset_q    <= 1'b0;
      pset_id_q <= ID_NONE;
      pset_m_q  <= '0;
    end else begin
      ackv_q <= ackv_d;
      pclr_q <= pclr_d;
      pset_q <= pset_d;
      if (take_ack) ackid_q <= ackid_d;
      if (ack_ok) begin
        pclr_id_q <= a_hp;
        pclr_m_q  <= pclr_m_d;
      end
      if (repend) begin
        pset_id_q <= eoi_id_i;
        pset_m_q  <= pset_m_d;
      end
    end
  end

  assign ack_valid_o     = ackv_q;
  assign ack_id_o        = ackid_q;
  assign run_id_o        = run_id;
  assign run_prio_o      = run_prio;
  assign busy_o          = (st_q == ST_WALK);
  assign pend_clr_o      = pclr_q;
  assign pend_clr_id_o   = pclr_id_q;
  assign pend_clr_mask_o = pclr_m_q;
  assign pend_set_o      = pset_q;
  assign pend_set_id_o   = pset_id_q;
  assign pend_set_mask_o = pset_m_q;

  // Walk length counter, only for the bound check
  logic [CNT_W-1:0] walk_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                walk_cnt_q <= '0;
    else if (st_q == ST_WALK)  walk_cnt_q <= walk_cnt_q + CNT_W'(1);
    else                       walk_cnt_q <= '0;
  end

  AST_WALK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (walk_cnt_q < CNT_W'(NUM_IRQ))); // R8

  AST_RUN_HELD_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(run_id_o)); // R7

  AST_CLR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr_o |-> (ack_valid_o && (ack_id_o != ID_NONE))); // R4

  AST_SET_ONE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    pend_set_o |-> ($countones(pend_set_mask_o) == 1)); // R9

  AST_ACK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid_o && (ack_id_o != ID_NONE)) |-> (ack_id_o < IRQ_LIM)); // R3

endmodule

// File: tb/irq_ack_tracker_bench.sv
`timescale 1ns/1ps
module irq_ack_tracker_bench;
  localparam int NC = 2;
  localparam int NI = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ack_req, eoi_req;
  logic        ack_cpu, eoi_cpu;
  logic [19:0] hp_v;
  logic [9:0]  eoi_id;
  logic [9:0]  prio_qry_id;
  logic        prio_qry_cpu;
  logic [7:0]  prio_qry_val;
  logic [63:0] trig_edge, one_of_n;
  logic [127:0] en_v, lev_v, tgt_v;
  logic        ack_valid, busy, pend_clr, pend_set;
  logic [9:0]  ack_id, pend_clr_id, pend_set_id;
  logic [19:0] run_id_v;
  logic [17:0] run_prio_v;
  logic [1:0]  pend_clr_mask, pend_set_mask;

  logic [7:0] prio_tab [NI];

  always #10 clk = ~clk;

  assign prio_qry_val = (prio_qry_id < 10'd64) ? prio_tab[prio_qry_id[5:0]] : 8'hFF;

  irq_ack_tracker #(.NUM_CPU(NC), .NUM_IRQ(NI)) u_irq_ack_tracker (
    .clk(clk), .rst_n(rst_n),
    .ack_req_i(ack_req), .ack_cpu_i(ack_cpu), .hp_id_i(hp_v),
    .eoi_req_i(eoi_req), .eoi_cpu_i(eoi_cpu), .eoi_id_i(eoi_id),
    .prio_qry_id_o(prio_qry_id), .prio_qry_cpu_o(prio_qry_cpu), .prio_qry_val_i(prio_qry_val),
    .trig_edge_i(trig_edge), .one_of_n_i(one_of_n),
    .en_i(en_v), .level_i(lev_v), .target_i(tgt_v),
    .ack_valid_o(ack_valid), .ack_id_o(ack_id),
    .run_id_o(run_id_v), .run_prio_o(run_prio_v), .busy_o(busy),
    .pend_clr_o(pend_clr), .pend_clr_id_o(pend_clr_id), .pend_clr_mask_o(pend_clr_mask),
    .pend_set_o(pend_set), .pend_set_id_o(pend_set_id), .pend_set_mask_o(pend_set_mask)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Reference model: per-processor stack of nested IDs
  int stk [NC][NI];
  int dep [NC];

  // Scoreboard queues
  int    q_ack[$];
  string q_ack_tag[$];
  int    q_clr_id[$], q_clr_m[$];
  int    q_set_id[$], q_set_m[$];

  function automatic int pr(int id);
    return (id < NI) ? int'(prio_tab[id]) : 255;
  endfunction
  function automatic int m_run(int c);
    return (dep[c] == 0) ? 1023 : stk[c][dep[c]-1];
  endfunction
  function automatic int m_prio(int c);
    return (dep[c] == 0) ? 256 : pr(stk[c][dep[c]-1]);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (ack_valid) begin
        if (q_ack.size() == 0) chk(1'b0, "R2", "unexpected ack", int'(ack_id), -1);
        else begin
          int e; string t;
          e = q_ack.pop_front(); t = q_ack_tag.pop_front();
          chk(int'(ack_id) == e, t, "ack id", int'(ack_id), e);
        end
      end
      if (pend_clr) begin
        if (q_clr_id.size() == 0) chk(1'b0, "R4", "unexpected pend clear", int'(pend_clr_id), -1);
        else begin
          int ei, em;
          ei = q_clr_id.pop_front(); em = q_clr_m.pop_front();
          chk(int'(pend_clr_id) == ei, "R4", "clear id", int'(pend_clr_id), ei);
          chk(int'(pend_clr_mask) == em, "R4", "clear mask", int'(pend_clr_mask), em);
        end
      end
      if (pend_set) begin
        if (q_set_id.size() == 0) chk(1'b0, "R9", "unexpected pend set", int'(pend_set_id), -1);
        else begin
          int ei, em;
          ei = q_set_id.pop_front(); em = q_set_m.pop_front();
          chk(int'(pend_set_id) == ei, "R9", "set id", int'(pend_set_id), ei);
          chk(int'(pend_set_mask) == em, "R9", "set mask", int'(pend_set_mask), em);
        end
      end
    end
  end

  task automatic do_ack(int c, int hp, string tag);
    int exp;
    exp = 1023;
    if (hp < NI && pr(hp) < m_prio(c)) exp = hp;
    q_ack.push_back(exp);
    q_ack_tag.push_back(tag);
    if (exp != 1023) begin
      q_clr_id.push_back(hp);
      q_clr_m.push_back(one_of_n[hp] ? 3 : (1 << c));
      stk[c][dep[c]] = hp;
      dep[c]++;
    end
    @(negedge clk);
    hp_v[c*10 +: 10] = 10'(hp);
    ack_cpu = 1'(c);
    ack_req = 1'b1;
    @(negedge clk);
    ack_req = 1'b0;
  endtask

  task automatic do_eoi(int c, int id, string tag);
    int exp_busy, pos, n, b;
    bit valid;
    exp_busy = 0;
    pos = -1;
    valid = (id < NI) && (dep[c] > 0);
    if (valid) begin
      b = id * NC + c;
      if (!trig_edge[id] && en_v[b] && lev_v[b] && tgt_v[b]) begin
        q_set_id.push_back(id);
        q_set_m.push_back(1 << c);
      end
      for (int j = dep[c] - 1; j >= 0; j--)
        if (pos < 0 && stk[c][j] == id) pos = j;
      if (pos == dep[c] - 1) begin
        dep[c]--;
      end else if (pos >= 0) begin
        exp_busy = dep[c] - 1 - pos;
        for (int j = pos; j < dep[c] - 1; j++) stk[c][j] = stk[c][j+1];
        dep[c]--;
      end else begin
        exp_busy = dep[c];
      end
    end
    @(negedge clk);
    eoi_cpu = 1'(c);
    eoi_id  = 10'(id);
    eoi_req = 1'b1;
    @(negedge clk);
    eoi_req = 1'b0;
    n = 0;
    while (busy && n < 200) begin
      n++;
      @(negedge clk);
    end
    chk(n == exp_busy, "R8", {tag, " busy cycles"}, n, exp_busy);
  endtask

  task automatic check_run(int c, string tag);
    int ai, ap;
    @(negedge clk);
    ai = int'(run_id_v[c*10 +: 10]);
    ap = int'(run_prio_v[c*9 +: 9]);
    chk(ai == m_run(c), tag, $sformatf("cpu%0d running id", c), ai, m_run(c));
    chk(ap == m_prio(c), tag, $sformatf("cpu%0d running prio", c), ap, m_prio(c));
  endtask

  initial begin
    for (int i = 0; i < NI; i++) prio_tab[i] = 8'(200 - 3 * i);
    for (int c = 0; c < NC; c++) dep[c] = 0;
    rst_n = 1'b0; ack_req = 0; eoi_req = 0; ack_cpu = 0; eoi_cpu = 0;
    hp_v = '1; eoi_id = '1;
    trig_edge = '1; one_of_n = '0; en_v = '0; lev_v = '0; tgt_v = '0;
    one_of_n[20] = 1'b1;
    trig_edge[50] = 1'b0; en_v[101] = 1'b1; lev_v[101] = 1'b1; tgt_v[101] = 1'b1;
    trig_edge[40] = 1'b0; en_v[80]  = 1'b1; lev_v[80]  = 1'b1; tgt_v[80]  = 1'b1;
    trig_edge[10] = 1'b0; en_v[20]  = 1'b0; lev_v[20]  = 1'b1; tgt_v[20]  = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(ack_valid == 1'b0 && pend_clr == 1'b0 && pend_set == 1'b0, "R1", "pulses after reset",
        int'(ack_valid), 0);
    check_run(0, "R1");
    check_run(1, "R1");

    // Acknowledge cases on cpu0
    do_ack(0, 1023, "R2");
    do_ack(0, 10, "R3");
    do_ack(0, 5, "R2");
    do_ack(0, 10, "R2");
    check_run(0, "R2");
    do_ack(0, 20, "R4");
    do_ack(0, 30, "R3");
    do_ack(0, 40, "R3");
    check_run(0, "R3");

    // Independence of processors
    check_run(1, "R10");
    do_ack(1, 50, "R3");
    check_run(0, "R10");
    check_run(1, "R3");

    // Ignored completions
    do_eoi(0, 1023, "R5");
    do_eoi(0, 100, "R5");
    check_run(0, "R5");

    // Pop with re-pend on cpu1, then completion with nothing running
    do_eoi(1, 50, "R6");
    check_run(1, "R6");
    do_eoi(1, 50, "R5");
    check_run(1, "R5");
    check_run(0, "R10");

    // Out-of-order completion in the middle of the chain
    do_eoi(0, 20, "R7");
    check_run(0, "R7");
    do_eoi(0, 40, "R9");
    check_run(0, "R6");
    do_eoi(0, 30, "R7");
    check_run(0, "R7");

    // ID absent from chain
    do_eoi(0, 33, "R7");
    check_run(0, "R7");

    // Level source disabled: no re-pend; chain empties
    do_eoi(0, 10, "R9");
    check_run(0, "R6");

    // Fresh nesting after unwinding
    do_ack(0, 60, "R3");
    do_ack(0, 50, "R2");
    check_run(0, "R3");
    do_eoi(0, 60, "R6");
    check_run(0, "R6");

    repeat (3) @(negedge clk);
    chk(q_ack.size() == 0, "R3", "ack answers missing", q_ack.size(), 0);
    chk(q_clr_id.size() == 0, "R4", "clear commands missing", q_clr_id.size(), 0);
    chk(q_set_id.size() == 0, "R9", "set commands missing", q_set_id.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule